// File: doc/BRIEF.md
# T1 Clear-Channel Transmit Payload Processor

This block sits in the transmit path of a T1 framer. It takes one payload octet per time slot, with 24 time slots per frame. For ordinary slots it makes two changes. In the signaling frames of a superframe it robs the least significant bit to carry a signaling bit. When the octet would otherwise leave the block as all zeros, it sets bit 7 to meet the ones-density rule (B7 stuffing). Framing bits, line coding and the signaling controller itself live elsewhere.

A 24-bit clear-channel mask, supplied as three octets, marks slots whose payload must pass untouched. Robbed-bit insertion and zero-code suppression both skip a marked slot. The robbed bit can come from an internal or an external signaling source, and the exemption holds for both. The result appears one clock after the input, with a valid strobe that travels alongside it.

Top module: `t1cc_tx_payload`

## Requirements
- R1: Mask mapping: `ccMaskA` bit 7 marks slot index 0, and the numbering runs down through each octet and on into the next, ending with `ccMaskC` bit 0 for slot index 23. A mask bit of 1 means clear.
- R2: A clear slot leaves the block unchanged in every frame, whatever the signaling inputs and the source select are.
- R3: In a non-clear slot during frame 6 or frame 12 (`frameIdx` counts 1 to 12), output bit 0 (the LSB) carries the selected signaling bit.
- R4: When `sigSel` is 0 the robbed bit is taken from `sigInt`. When `sigSel` is 1 it is taken from `sigExt`.
- R5: In a non-clear slot outside frames 6 and 12, the signaling inputs have no effect. A non-zero octet passes unchanged.
- R6: Zero-code suppression is applied after signaling insertion. If a non-clear slot's octet is 0x00 at that point, the output is 0x02 (bit 7, counting the MSB as bit 1, is forced to 1).
- R7: `outValid` follows `inValid` by exactly one clock, and `dataOut` is updated on that same edge.
- R8: While reset is asserted, `outValid` and `dataOut` are both 0.
- R9: A slot index of 24 or above is treated as clear, and its octet passes unchanged.
- R10: A clock edge with `inValid` low leaves `dataOut` holding its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input octet is valid |
| slotIdx | input | 5 | Time slot index, 0 to 23 |
| frameIdx | input | 4 | Frame within the superframe, 1 to 12 |
| dataIn | input | 8 | Payload octet |
| sigInt | input | 1 | Signaling bit from the internal source |
| sigExt | input | 1 | Signaling bit from the external source |
| sigSel | input | 1 | Signaling source select: 0 internal, 1 external |
| ccMaskA | input | 8 | Clear-channel bits for slots 0 to 7 |
| ccMaskB | input | 8 | Clear-channel bits for slots 8 to 15 |
| ccMaskC | input | 8 | Clear-channel bits for slots 16 to 23 |
| outValid | output | 1 | Output octet is valid |
| dataOut | output | 8 | Processed octet |

## Verification
The bench sweeps every slot under random masks. A design that reversed the bit order inside an octet, or reversed the order of the three octets, would alter slots that should be clear and leave clear the ones that should be altered. All-zero octets are sent into clear and non-clear slots, in both signaling and non-signaling frames. Running suppression before insertion would emit 0x00 or 0x03 where 0x02 or 0x01 is expected, and stuffing a clear slot would turn its 0x00 into 0x02. Both signaling sources are driven with opposite values, so a swapped or ignored select shows up in bit 0. Out-of-range slot indices and idle cycles are also exercised, which catches an index that wraps into the mask and an output register that loads while no input is valid.

// File: rtl/t1cc_pkg.sv
package t1cc_pkg;
  // Strobes passed from the slot/frame decode into the datapath
  typedef struct packed {
    logic clearSlot;  // slot exempt from every change
    logic sigFrame;   // current frame carries robbed-bit signaling
    logic sigBit;     // signaling bit from the selected source
  } ccCtrl_t;
endpackage

// File: rtl/t1cc_ctrl.sv
module t1cc_ctrl
  import t1cc_pkg::*;
#(
  parameter int SLOTS       = 24,
  parameter int SLOT_W      = 5,
  parameter int FRAME_W     = 4,
  parameter int SIG_FRAME_A = 6,
  parameter int SIG_FRAME_B = 12
) (
  input  logic [SLOT_W-1:0]  slotIdx,
  input  logic [FRAME_W-1:0] frameIdx,
  input  logic [SLOTS-1:0]   ccMask,
  input  logic               sigInt,
  input  logic               sigExt,
  input  logic               sigSel,
  output ccCtrl_t            ctrl
);
  logic [SLOTS-1:0] hitVec;
  logic             outOfRange;

  // The most significant mask bit belongs to slot index 0
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hitVec[s] = (slotIdx == SLOT_W'(s)) & ccMask[SLOTS-1-s];
  end

  assign outOfRange = (slotIdx >= SLOT_W'(SLOTS));

  always_comb begin
    ctrl.clearSlot = (|hitVec) | outOfRange;
    ctrl.sigFrame  = (frameIdx == FRAME_W'(SIG_FRAME_A)) ||
                     (frameIdx == FRAME_W'(SIG_FRAME_B));
    ctrl.sigBit    = sigSel ? sigExt : sigInt;
  end

  // R9: out-of-range slots must decode as clear
  always_comb begin
    assert_range_clear_R9: assert (!outOfRange || ctrl.clearSlot);
  end
endmodule

// File: rtl/t1cc_dp.sv
module t1cc_dp
  import t1cc_pkg::*;
#(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OCT_W-1:0] dataIn,
  input  ccCtrl_t          ctrl,
  output logic             outValid,
  output logic [OCT_W-1:0] dataOut
);
  localparam int STUFF_POS = 1;  // bit 7 when the MSB is counted as bit 1

  logic [OCT_W-1:0] robbed;
  logic [OCT_W-1:0] stuffed;

  always_comb begin
    robbed = dataIn;
    if (!ctrl.clearSlot && ctrl.sigFrame) robbed[0] = ctrl.sigBit;
    stuffed = robbed;
    if (!ctrl.clearSlot && (robbed == '0)) stuffed[STUFF_POS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dataOut  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) dataOut <= stuffed;
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
  assert_clear_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(ctrl.clearSlot)) |-> dataOut == $past(dataIn));
  assert_no_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(ctrl.clearSlot)) |-> dataOut != '0);
  assert_sig_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(ctrl.clearSlot) && $past(ctrl.sigFrame))
      |-> dataOut[0] == $past(ctrl.sigBit));
  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> dataOut[OCT_W-1:2] == $past(dataIn[OCT_W-1:2]));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> $stable(dataOut));
endmodule

// File: rtl/t1cc_tx_payload.sv
module t1cc_tx_payload
  import t1cc_pkg::*;
#(
  parameter int SLOTS       = 24,
  parameter int MASK_OCT    = 8,
  parameter int FRAME_W     = 4,
  parameter int SIG_FRAME_A = 6,
  parameter int SIG_FRAME_B = 12,
  parameter int OCT_W       = 8,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SLOT_W-1:0]  slotIdx,
  input  logic [FRAME_W-1:0] frameIdx,
  input  logic [OCT_W-1:0]   dataIn,
  input  logic               sigInt,
  input  logic               sigExt,
  input  logic               sigSel,
  input  logic [MASK_OCT-1:0] ccMaskA,
  input  logic [MASK_OCT-1:0] ccMaskB,
  input  logic [MASK_OCT-1:0] ccMaskC,
  output logic               outValid,
  output logic [OCT_W-1:0]   dataOut
);
  ccCtrl_t          ctrl;
  logic [SLOTS-1:0] ccMask;

  assign ccMask = SLOTS'({ccMaskA, ccMaskB, ccMaskC});

  t1cc_ctrl #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W),
    .SIG_FRAME_A(SIG_FRAME_A), .SIG_FRAME_B(SIG_FRAME_B)
  ) uCtrl (
    .slotIdx(slotIdx), .frameIdx(frameIdx), .ccMask(ccMask),
    .sigInt(sigInt), .sigExt(sigExt), .sigSel(sigSel), .ctrl(ctrl)
  );

  t1cc_dp #(.OCT_W(OCT_W)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dataIn(dataIn),
    .ctrl(ctrl), .outValid(outValid), .dataOut(dataOut)
  );
endmodule

// File: tb/sim_t1cc_tx_payload.sv
`timescale 1ns/1ps
module sim_t1cc_tx_payload;
  logic clk = 0, rstN = 0, inValid = 0;
  logic [4:0] slotIdx = 0;
  logic [3:0] frameIdx = 1;
  logic [7:0] dataIn = 0;
  logic sigInt = 0, sigExt = 0, sigSel = 0;
  logic [7:0] ccMaskA = 0, ccMaskB = 0, ccMaskC = 0;
  logic outValid;
  logic [7:0] dataOut;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  t1cc_tx_payload u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected octet, written from the requirements
  function automatic logic [7:0] refOut(input logic [23:0] m, input int slot,
      input int frame, input logic [7:0] d, input logic sb);
    logic [7:0] r;
    if (slot > 23 || m[23-slot]) return d;
    r = d;
    if (frame == 6 || frame == 12) r[0] = sb;
    if (r == 8'h00) r = 8'h02;
    return r;
  endfunction

  // Drive one valid octet at a falling edge and sample at the next falling edge
  task automatic step(input string req, input int slot, input int frame,
      input logic [7:0] d, input logic si, input logic se, input logic sel);
    logic [7:0] exp;
    slotIdx = 5'(slot); frameIdx = 4'(frame); dataIn = d;
    sigInt = si; sigExt = se; sigSel = sel; inValid = 1;
    exp = refOut({ccMaskA, ccMaskB, ccMaskC}, slot, frame, d, sel ? se : si);
    @(posedge clk); @(negedge clk);
    inValid = 0;
    check(req, dataOut, exp);
    check({req, " valid"}, {7'd0, outValid}, 8'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R8 outValid", {7'd0, outValid}, 8'd0);
    check("R8 dataOut", dataOut, 8'h00);
    rstN = 1;
  endtask

  task automatic testMapping();  // R1, R2
    for (int k = 0; k < 4; k++) begin
      {ccMaskA, ccMaskB, ccMaskC} = 24'($urandom);
      for (int s = 0; s < 24; s++) begin
        step("R1", s, 6, 8'h00, 1'b0, 1'b1, 1'b0);
        step("R2", s, 12, 8'hA4, 1'b1, 1'b1, 1'b1);
      end
    end
  endtask

  task automatic testZeros();  // R3, R5, R6
    {ccMaskA, ccMaskB, ccMaskC} = 24'h800001;
    for (int f = 1; f <= 12; f++) begin
      step("R6", 3, f, 8'h00, 1'b0, 1'b0, 1'b0);
      step("R3", 3, f, 8'h00, 1'b1, 1'b0, 1'b0);
      step("R2", 0, f, 8'h00, 1'b1, 1'b1, 1'b0);
      step("R2", 23, f, 8'h01, 1'b0, 1'b0, 1'b1);
      step("R5", 5, f, 8'h5B, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic testSources();  // R4
    {ccMaskA, ccMaskB, ccMaskC} = 24'h000000;
    step("R4 int", 7, 6, 8'hF0, 1'b1, 1'b0, 1'b0);
    step("R4 ext", 7, 6, 8'hF1, 1'b1, 1'b0, 1'b1);
    step("R4 ext", 9, 12, 8'hF0, 1'b0, 1'b1, 1'b1);
    step("R4 int", 9, 12, 8'hF1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testRangeHold();  // R9, R10, R7
    {ccMaskA, ccMaskB, ccMaskC} = 24'h000000;
    step("R9", 24, 6, 8'h00, 1'b1, 1'b1, 1'b0);
    step("R9", 31, 12, 8'h00, 1'b1, 1'b0, 1'b1);
    step("R7", 2, 1, 8'h37, 1'b0, 1'b0, 1'b0);
    dataIn = 8'hC3; slotIdx = 0; frameIdx = 1; inValid = 0;
    @(posedge clk); @(negedge clk);
    check("R10 hold", dataOut, 8'h37);
    check("R7 idle", {7'd0, outValid}, 8'd0);
  endtask

  initial begin
    testReset();
    testMapping();
    testZeros();
    testSources();
    testRangeHold();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule